// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable-logic device. It receives one sum-of-products term from the logic array and turns it into the level on a bidirectional pin. It also sends one feedback signal back into the array. A two-bit mode setting fixes the cell's behaviour. The high bit chooses between a combinational path and a D flip-flop path. The low bit chooses the output polarity.

The flip-flop has two controls driven by array terms. One is an asynchronous clear, which also wins over the preset. The other is a synchronous preset. The chip reset `rst_ni` also clears the flip-flop. The pin is driven only while the output-enable term is high. When it is low, the pin floats, so that an outside driver can use it as an input. The same high mode bit selects the feedback source: the flip-flop in registered modes, and the pin level in combinational modes.

Top module: `olmc_cell`

## Requirements
- R1: With mode 2'b11 and `oe_i`=1, `pad_io` equals `sop_i`, with no clock involved.
- R2: With mode 2'b10 and `oe_i`=1, `pad_io` equals the inverse of `sop_i`, with no clock involved.
- R3: With mode 2'b01, each rising clock edge stores `sop_i` in the flip-flop, and `pad_io` (when `oe_i`=1) shows the stored bit.
- R4: With mode 2'b00, the flip-flop is loaded the same way, and `pad_io` (when `oe_i`=1) shows the inverse of the stored bit.
- R5: In modes 2'b10 and 2'b11, the flip-flop state, including a clear or a preset, has no effect on `pad_io`.
- R6: While `areset_i`=1, the flip-flop reads 0 at once, without waiting for a clock edge, and it stays 0 across clock edges even when `spreset_i`=1.
- R7: With `spreset_i`=1 and `areset_i`=0, the next rising clock edge sets the flip-flop to 1, whatever the value of `sop_i`.
- R8: With mode bit 1 = 0, `fb_o` equals the stored flip-flop bit, whatever the polarity bit and `oe_i` are.
- R9: With mode bit 1 = 1, `fb_o` equals the level on `pad_io`. That level is either the cell's own drive or an outside driver's level.
- R10: With `oe_i`=0, the cell does not drive `pad_io`, so an outside driver sets its level with no contention.
- R11: While `rst_ni`=0, the flip-flop is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Flip-flop clock |
| rst_ni | input | 1 | Chip reset, active low, asynchronous |
| mode_i | input | 2 | Mode: bit 1 = combinational, bit 0 = active-high output |
| sop_i | input | 1 | Sum-of-products term from the array |
| areset_i | input | 1 | Asynchronous clear term, active high |
| spreset_i | input | 1 | Synchronous preset term, active high |
| oe_i | input | 1 | Pin output enable |
| pad_io | inout | 1 | Bidirectional pin |
| fb_o | output | 1 | Feedback to the array |

## Verification
Two events can land in the same cycle: an asynchronous clear and a synchronous preset, and each tries to move the flip-flop a different way. The sweep drives every combination of sum term, preset, clear and enable in all four modes, and holds each combination across a rising edge. The bench then compares the pin and the feedback with a requirement model in which the clear wins. It checks once in the middle of the cycle and once just after the edge. This also shows that the clear acts before the edge arrives, and that the combinational modes ignore both controls.

// File: rtl/olmc_pkg.sv
package olmc_pkg;
  localparam int MODE_W = 2;
  localparam int COMB_BIT = 1;
  localparam int POL_BIT = 0;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } olmc_mode_e;

  function automatic logic is_comb(input logic [MODE_W-1:0] m);
    return m[COMB_BIT];
  endfunction

  function automatic logic is_high(input logic [MODE_W-1:0] m);
    return m[POL_BIT];
  endfunction
endpackage

// File: rtl/olmc_flop.sv
module olmc_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic areset_i,
  input  logic spreset_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge areset_i) begin
    if (!rst_ni)        q_o <= 1'b0;
    else if (areset_i)  q_o <= 1'b0;
    else if (spreset_i) q_o <= 1'b1;
    else                q_o <= d_i;
  end

  a_r6_clear_dominates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    areset_i |-> !q_o);
  a_r7_preset_sets: assert property (@(posedge clk_i) disable iff (!rst_ni || areset_i)
    spreset_i |=> q_o);
  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni || areset_i)
    !spreset_i |=> q_o == $past(d_i));
endmodule

// File: rtl/olmc_out_sel.sv
module olmc_out_sel
  import olmc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sop_i,
  input  logic              q_i,
  output logic              out_o
);
  logic raw;
  always_comb begin
    raw   = is_comb(mode_i) ? sop_i : q_i;
    out_o = is_high(mode_i) ? raw : ~raw;
  end
endmodule

// File: rtl/olmc_fb_sel.sv
module olmc_fb_sel
  import olmc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              q_i,
  input  logic              pin_i,
  output logic              fb_o
);
  // only the combinational bit steers feedback
  assign fb_o = is_comb(mode_i) ? pin_i : q_i;
endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
  import olmc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sop_i,
  input  logic              areset_i,
  input  logic              spreset_i,
  input  logic              oe_i,
  inout  wire               pad_io,
  output logic              fb_o
);
  logic q;
  logic out_val;

  olmc_flop i_flop (
    .clk_i, .rst_ni, .areset_i, .spreset_i,
    .d_i (sop_i),
    .q_o (q)
  );

  olmc_out_sel i_out_sel (
    .mode_i, .sop_i,
    .q_i   (q),
    .out_o (out_val)
  );

  assign pad_io = oe_i ? out_val : 1'bz;

  olmc_fb_sel i_fb_sel (
    .mode_i,
    .q_i   (q),
    .pin_i (pad_io),
    .fb_o
  );

  a_r1_comb_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && mode_i == MODE_COMB_HIGH) |-> pad_io == sop_i);
  a_r2_comb_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && mode_i == MODE_COMB_LOW) |-> pad_io == !sop_i);
  a_r8_fb_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[COMB_BIT] |-> fb_o == q);
  a_r9_fb_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[COMB_BIT] |-> fb_o == pad_io);
endmodule

// File: tb/test_olmc_cell.sv
module test_olmc_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic sop = 1'b0, arst = 1'b0, spre = 1'b0, oe = 1'b1;
  logic ext_en = 1'b0, ext_v = 1'b0;
  wire pad;
  logic fb;
  int n_run = 0, n_fail = 0;
  logic q_m = 1'b0;

  always #2 clk = ~clk;

  assign pad = ext_en ? ext_v : 1'bz;

  olmc_cell i_olmc_cell (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sop_i(sop),
    .areset_i(arst), .spreset_i(spre), .oe_i(oe), .pad_io(pad), .fb_o(fb)
  );

  // requirement model of the stored bit (R3, R6, R7, R11)
  always @(posedge clk or negedge rst_n or posedge arst) begin
    if (!rst_n || arst) q_m <= 1'b0;
    else if (spre)      q_m <= 1'b1;
    else                q_m <= sop;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (mode=%b sop=%b ar=%b sp=%b oe=%b)",
               req, act, exp, mode, sop, arst, spre, oe);
    end
  endtask

  task automatic check_all();
    logic qe, drv, pexp;
    qe  = (arst || !rst_n) ? 1'b0 : q_m;
    drv = mode[1] ? sop : qe;
    if (!mode[0]) drv = ~drv;
    pexp = oe ? drv : ext_v;
    case ({oe, mode})
      3'b111: chk("R1", pad, pexp);
      3'b110: chk("R2", pad, pexp);
      3'b101: chk("R3", pad, pexp);
      3'b100: chk("R4", pad, pexp);
      default: chk("R10", pad, pexp);
    endcase
    if (oe && mode[1] && (arst || spre)) chk("R5", pad, mode[0] ? sop : ~sop);
    if (mode[1]) chk("R9", fb, pexp);
    else         chk("R8", fb, qe);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #5;
    chk("R11", pad, 1'b0);
    chk("R8", fb, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 64; p++) begin
        @(negedge clk);
        mode = m[1:0];
        sop  = p[0];
        spre = p[1];
        arst = p[2];
        oe   = p[3];
        ext_v  = p[4];
        ext_en = !oe;
        #1 check_all();
        @(posedge clk);
        #1 check_all();
        if (p[5]) begin
          @(negedge clk);
          arst = 1'b0;
          spre = 1'b0;
          sop  = ~sop;
          #1 check_all();
          @(posedge clk);
          #1 check_all();
        end
      end
    end
    // R6: clear mid-cycle after a preset load, no clock edge in between
    @(negedge clk);
    mode = 2'b01; oe = 1'b1; ext_en = 1'b0; arst = 1'b0; spre = 1'b1;
    @(posedge clk); #1 chk("R7", pad, 1'b1);
    spre = 1'b0; arst = 1'b1;
    #0.5 chk("R6", pad, 1'b0);
    @(negedge clk); arst = 1'b0;
    // R11: chip reset clears the flip-flop at once
    spre = 1'b1;
    @(posedge clk); #1 chk("R7", fb, 1'b1);
    rst_n = 1'b0;
    #0.5 chk("R11", fb, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule